// File: doc/BRIEF.md
# CAN Transmit Arbitration Monitor

This block sits between the serialiser that produces a CAN frame one bit at a time and the bus transceiver. At each bit-start strobe it latches the next bit and drives it onto the transmit line. At each sample strobe it compares that bit with the received bus level. The bus behaves as a wired-AND: a dominant 0 from any node overrides a recessive 1.

If the node sends recessive inside the arbitration field and reads dominant, another node with higher priority has won. The block then holds the transmit line recessive until the frame ends, and reports the loss with a one-cycle pulse so the frame can be queued for a later attempt. The node that wins never observes the collision. Any other mismatch is reported as a bit error. A recessive level read back in the acknowledge slot is reported as a missing acknowledge.

A loopback mode routes the transmitted bit straight to the receive output and keeps the bus recessive. Missing acknowledges are not flagged in this mode. The stream has no back-pressure: strobes arrive at the bit rate set by the bit-timing logic, and every result is a single-cycle pulse that cannot be stalled.

Top module: `can_arb_monitor`

## Requirements
- R1: After reset, tx_o is 1 (recessive), lb_rx_o is 1, and arb_lost_o, bit_err_o and ack_missing_o are 0.
- R2: On a clock with bit_start_i high, tx_bit_i is latched, and tx_o shows it from the next cycle until the next bit_start_i or frame_end_i.
- R3: A sample strobe where the node sends 1 and reads 0, with arb_field_i high, gives one arb_lost_o pulse in the next cycle and no bit_err_o.
- R4: After arbitration is lost, tx_o stays 1 across later bit starts, and no pulse is raised until frame_end_i.
- R5: frame_end_i ends the withdrawn state and sets tx_o to 1. The next bit_start_i drives tx_bit_i again.
- R6: A sample where the sent bit equals the read bit raises no pulse, for both 0 and 1.
- R7: Sending 1 and reading 0 at a sample strobe, with arb_field_i and ack_slot_i both low, gives one bit_err_o pulse in the next cycle.
- R8: Sending 0 and reading 1 at a sample strobe gives a bit_err_o pulse, even inside the arbitration field.
- R9: In the acknowledge slot (ack_slot_i high), reading 1 gives an ack_missing_o pulse in the next cycle. Reading 0 is a valid acknowledge and raises no pulse.
- R10: With loopback_i high, tx_o is 1, lb_rx_o equals the latched transmit bit, and no pulse is raised, including in the acknowledge slot.
- R11: Outside loopback, rx_i passes through SYNC_STAGES flip-flops (default 2) before it reaches lb_rx_o and the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| bit_start_i | input | 1 | Strobe: latch the next bit |
| sample_i | input | 1 | Strobe: sample point of the bit |
| tx_bit_i | input | 1 | Next bit to send (0 dominant) |
| arb_field_i | input | 1 | Current bit is in the arbitration field |
| ack_slot_i | input | 1 | Current bit is the acknowledge slot |
| frame_end_i | input | 1 | Frame finished; clear withdrawal |
| loopback_i | input | 1 | Internal loopback enable |
| rx_i | input | 1 | Bus receive level |
| tx_o | output | 1 | Bus transmit level |
| arb_lost_o | output | 1 | Pulse: arbitration lost |
| bit_err_o | output | 1 | Pulse: bit error |
| ack_missing_o | output | 1 | Pulse: no acknowledge seen |
| lb_rx_o | output | 1 | Receive level for the controller |

## Verification
A change of tx_o is due one cycle after the bit_start_i edge. Each event pulse is due exactly one cycle after the sample_i edge. A change on rx_i reaches lb_rx_o after SYNC_STAGES edges. For every sample strobe, the driver queues the expected event pattern. The monitor compares outputs a quarter period after each rising edge: on the edge that follows a strobe it pops the queued pattern, and on every other edge it requires all pulses to be low. The driver waits past the synchroniser latency before it raises a sample, and both tx_o and lb_rx_o are read on a falling edge.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_ARB  = 2'd1,
    EV_BIT  = 2'd2,
    EV_ACK  = 2'd3
  } bit_event_e;
  localparam logic RECESSIVE = 1'b1;
  localparam logic DOMINANT  = 1'b0;
endpackage

// File: rtl/can_rx_sync.sv
module can_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else if (STAGES == 1) chain_q <= d_i;
        else chain_q <= {chain_q[STAGES-2:0], d_i};
      end
      assign q_o = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/can_tx_driver.sv
module can_tx_driver
  import can_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_start_i,
  input  logic tx_bit_i,
  input  logic frame_end_i,
  input  logic lose_i,
  output logic tx_q_o,
  output logic withdrawn_o
);
  logic tx_q, withdrawn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q        <= RECESSIVE;
      withdrawn_q <= 1'b0;
    end else if (frame_end_i) begin
      tx_q        <= RECESSIVE;
      withdrawn_q <= 1'b0;
    end else if (lose_i) begin
      tx_q        <= RECESSIVE;
      withdrawn_q <= 1'b1;
    end else if (bit_start_i) begin
      tx_q <= withdrawn_q ? RECESSIVE : tx_bit_i;
    end
  end

  assign tx_q_o      = tx_q;
  assign withdrawn_o = withdrawn_q;
endmodule

// File: rtl/can_bit_compare.sv
module can_bit_compare
  import can_arb_pkg::*;
(
  input  logic       sample_i,
  input  logic       sent_i,
  input  logic       seen_i,
  input  logic       arb_field_i,
  input  logic       ack_slot_i,
  input  logic       withdrawn_i,
  input  logic       loopback_i,
  output bit_event_e event_o
);
  always_comb begin
    event_o = EV_NONE;
    if (sample_i && !withdrawn_i) begin
      if (ack_slot_i && sent_i == RECESSIVE) begin
        if (seen_i == RECESSIVE && !loopback_i) event_o = EV_ACK;
      end else if (sent_i == DOMINANT && seen_i == RECESSIVE) begin
        event_o = EV_BIT;
      end else if (sent_i == RECESSIVE && seen_i == DOMINANT) begin
        event_o = arb_field_i ? EV_ARB : EV_BIT;
      end
    end
  end
endmodule

// File: rtl/can_event_reg.sv
module can_event_reg
  import can_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bit_event_e event_i,
  output logic       arb_lost_o,
  output logic       bit_err_o,
  output logic       ack_missing_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_lost_o    <= 1'b0;
      bit_err_o     <= 1'b0;
      ack_missing_o <= 1'b0;
    end else begin
      arb_lost_o    <= (event_i == EV_ARB);
      bit_err_o     <= (event_i == EV_BIT);
      ack_missing_o <= (event_i == EV_ACK);
    end
  end
endmodule

// File: rtl/can_arb_monitor.sv
module can_arb_monitor
  import can_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_start_i,
  input  logic sample_i,
  input  logic tx_bit_i,
  input  logic arb_field_i,
  input  logic ack_slot_i,
  input  logic frame_end_i,
  input  logic loopback_i,
  input  logic rx_i,
  output logic tx_o,
  output logic arb_lost_o,
  output logic bit_err_o,
  output logic ack_missing_o,
  output logic lb_rx_o
);
  logic       rx_sync, tx_q, withdrawn, seen;
  bit_event_e ev;

  can_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_sync)
  );

  can_tx_driver u_drv (
    .clk(clk), .rst_n(rst_n), .bit_start_i(bit_start_i), .tx_bit_i(tx_bit_i),
    .frame_end_i(frame_end_i), .lose_i(ev == EV_ARB),
    .tx_q_o(tx_q), .withdrawn_o(withdrawn)
  );

  assign seen    = loopback_i ? tx_q : rx_sync;
  assign tx_o    = loopback_i ? RECESSIVE : tx_q;
  assign lb_rx_o = seen;

  can_bit_compare u_cmp (
    .sample_i(sample_i), .sent_i(tx_q), .seen_i(seen),
    .arb_field_i(arb_field_i), .ack_slot_i(ack_slot_i),
    .withdrawn_i(withdrawn), .loopback_i(loopback_i), .event_o(ev)
  );

  can_event_reg u_evr (
    .clk(clk), .rst_n(rst_n), .event_i(ev),
    .arb_lost_o(arb_lost_o), .bit_err_o(bit_err_o), .ack_missing_o(ack_missing_o)
  );
endmodule

// File: rtl/can_arb_monitor_chk.sv
module can_arb_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_start_i,
  input logic frame_end_i,
  input logic loopback_i,
  input logic tx_o,
  input logic arb_lost_o,
  input logic bit_err_o,
  input logic ack_missing_o
);
  assert_one_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arb_lost_o, bit_err_o, ack_missing_o}));

  assert_lost_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost_o |=> !arb_lost_o);

  assert_lost_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost_o |-> tx_o);

  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!loopback_i && !$past(loopback_i) && !$past(bit_start_i) && !$past(frame_end_i))
      |-> $stable(tx_o));

  assert_loop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (loopback_i && $past(loopback_i)) |-> (!ack_missing_o && !arb_lost_o && tx_o));
endmodule

bind can_arb_monitor can_arb_monitor_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bit_start_i(bit_start_i), .frame_end_i(frame_end_i),
  .loopback_i(loopback_i), .tx_o(tx_o), .arb_lost_o(arb_lost_o),
  .bit_err_o(bit_err_o), .ack_missing_o(ack_missing_o)
);

// File: tb/can_arb_monitor_tb_top.sv
module can_arb_monitor_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_start_i = 0, sample_i = 0, tx_bit_i = 1, arb_field_i = 0;
  logic ack_slot_i = 0, frame_end_i = 0, loopback_i = 0, rx_i = 1;
  logic tx_o, arb_lost_o, bit_err_o, ack_missing_o, lb_rx_o;

  int total = 0, bad = 0;
  logic [2:0] q_ev[$];
  string      q_req[$];
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_arb_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .bit_start_i(bit_start_i), .sample_i(sample_i),
    .tx_bit_i(tx_bit_i), .arb_field_i(arb_field_i), .ack_slot_i(ack_slot_i),
    .frame_end_i(frame_end_i), .loopback_i(loopback_i), .rx_i(rx_i),
    .tx_o(tx_o), .arb_lost_o(arb_lost_o), .bit_err_o(bit_err_o),
    .ack_missing_o(ack_missing_o), .lb_rx_o(lb_rx_o)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: events {arb,bit,ack}, due one edge after a sample strobe
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      if (sample_i) begin
        if (q_ev.size() == 0) check("queue", 8'hee, 8'h00);
        else check(q_req.pop_front(), {5'd0, arb_lost_o, bit_err_o, ack_missing_o},
                   {5'd0, q_ev.pop_front()});
      end else if ({arb_lost_o, bit_err_o, ack_missing_o} != 3'b000) begin
        check("spurious", {5'd0, arb_lost_o, bit_err_o, ack_missing_o}, 8'h00);
      end
    end
  end

  // driver: one bit, optional tx_o check, then sample with expected events
  task automatic do_bit(logic tx, logic rx, logic arb, logic ack,
                        logic exp_tx, logic [2:0] exp_ev, string req);
    @(negedge clk);
    bit_start_i = 1; tx_bit_i = tx; rx_i = rx; arb_field_i = arb; ack_slot_i = ack;
    @(negedge clk);
    bit_start_i = 0;
    check({req, " tx_o"}, {7'd0, tx_o}, {7'd0, exp_tx});
    repeat (3) @(negedge clk);
    sample_i = 1;
    q_ev.push_back(exp_ev); q_req.push_back(req);
    @(negedge clk);
    sample_i = 0;
    @(negedge clk);
  endtask

  task automatic end_frame();
    @(negedge clk); frame_end_i = 1; arb_field_i = 0; ack_slot_i = 0;
    @(negedge clk); frame_end_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 tx_o", {7'd0, tx_o}, 8'd1);
    check("R1 lb_rx_o", {7'd0, lb_rx_o}, 8'd1);
    check("R1 events", {5'd0, arb_lost_o, bit_err_o, ack_missing_o}, 8'd0);
    rst_n = 1;
    // R2/R6: matching bits in arbitration
    do_bit(0, 0, 1, 0, 0, 3'b000, "R6 dom match");
    do_bit(1, 1, 1, 0, 1, 3'b000, "R6 rec match");
    do_bit(0, 0, 1, 0, 0, 3'b000, "R2 tx follows");
    // R3: lose arbitration
    do_bit(1, 0, 1, 0, 1, 3'b100, "R3 arb lost");
    // R4: withdrawn, tx held recessive, no events
    do_bit(0, 0, 1, 0, 1, 3'b000, "R4 withdrawn dom");
    do_bit(0, 1, 0, 0, 1, 3'b000, "R4 withdrawn mismatch");
    end_frame();
    @(negedge clk);
    check("R5 tx_o after end", {7'd0, tx_o}, 8'd1);
    do_bit(0, 0, 1, 0, 0, 3'b000, "R5 drives again");
    // R7/R8
    do_bit(1, 0, 0, 0, 1, 3'b010, "R7 rec->dom data");
    do_bit(0, 1, 1, 0, 0, 3'b010, "R8 dom->rec arb");
    do_bit(0, 1, 0, 0, 0, 3'b010, "R8 dom->rec data");
    // R9: acknowledge slot
    do_bit(1, 1, 0, 1, 1, 3'b001, "R9 no ack");
    do_bit(1, 0, 0, 1, 1, 3'b000, "R9 ack seen");
    end_frame();
    // R10: loopback
    @(negedge clk); loopback_i = 1;
    do_bit(0, 1, 1, 0, 1, 3'b000, "R10 lb dom");
    check("R10 lb_rx_o", {7'd0, lb_rx_o}, 8'd0);
    do_bit(1, 1, 0, 1, 1, 3'b000, "R10 lb ack slot");
    check("R10 lb_rx_o rec", {7'd0, lb_rx_o}, 8'd1);
    end_frame();
    @(negedge clk); loopback_i = 0;
    // R11: synchroniser latency
    rx_i = 1; repeat (4) @(negedge clk);
    rx_i = 0;
    @(negedge clk);
    check("R11 one edge", {7'd0, lb_rx_o}, 8'd1);
    @(negedge clk);
    check("R11 two edges", {7'd0, lb_rx_o}, 8'd0);
    repeat (3) @(negedge clk);
    check("queue drained", q_ev.size()[7:0], 8'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule